// File: doc/BRIEF.md
# Double-Buffered Converter Code and Control Register Bank

This block keeps the 10-bit output code and the three control flags of a voltage-output converter. It sits behind a two-wire serial front end that has already decoded addresses and bus conditions. The front end hands it acknowledged data bytes on a valid/ready stream, plus single-cycle pulses for START (or repeated START), STOP and a broadcast sync quick command together with that command's data bit. The bank writes these into an input stage. It copies the input stage to the output stage that drives the converter only at a well-defined update event.

Writes arrive as frames. The first byte after a boundary is the control byte, the second is the low code byte and the third is the high code byte. The control byte selects how updates happen. In normal mode a STOP updates the outputs. In synchronous mode only a broadcast sync command updates them, so that several converters on one bus can change together. A sync command whose data bit is 0 always clears the whole bank. The byte stream is never back-pressured: `rx_ready` is held high and a byte counts in every cycle where `rx_valid` is high.

Top module: `dac_dbuf_regs`

## Requirements
- R1: After reset, `dac_code` is 0 and `pwr_down` and `ref_internal` are 0, and the input stage holds the same zero values.
- R2: In the control byte (first byte of a frame), bit 0 selects synchronous update mode (1 = sync command only, 0 = STOP). Bit 1 requests power-down. Bit 2 selects the internal reference (1) over the supply (0). Bits 7..3 have no effect.
- R3: The low code byte gives code bits 7..0. Bits 1..0 of the high code byte give code bits 9..8, and its bits 7..2 have no effect.
- R4: With synchronous mode off, a STOP loads the code, the power-down flag and the reference flag into the outputs together, visible one cycle after the STOP pulse. Outputs never change in a cycle that follows neither a STOP nor a sync command.
- R5: With synchronous mode on, a STOP leaves all outputs unchanged.
- R6: With synchronous mode on, a sync command with data bit 1 loads the input stage into the outputs one cycle after the pulse.
- R7: A sync command with data bit 0 clears the input stage and the outputs to the reset values, in either mode, one cycle after the pulse.
- R8: With synchronous mode off, a sync command with data bit 1 has no effect.
- R9: A START or STOP after the control byte but before the high code byte keeps the new control byte and discards the code bytes. The input code stays at its previous value.
- R10: A START or STOP returns the byte position to the control byte. A frame cut off before its control byte changes nothing.
- R11: Power-down keeps all stored data, and the previous code shows again once power-down is turned off.
- R12: `rx_ready` is always high. Bytes after the third in a frame have no effect.
- R13: When events coincide, a clearing sync command wins over STOP, START and bytes, and a START or STOP wins over a byte in the same cycle (that byte is dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: START or repeated START seen |
| frame_stop | input | 1 | Pulse: STOP seen |
| rx_valid | input | 1 | Acknowledged byte present |
| rx_ready | output | 1 | Always high; no back-pressure |
| rx_data | input | 8 | Acknowledged byte value |
| sync_hit | input | 1 | Pulse: acknowledge clock of broadcast sync command |
| sync_arg | input | 1 | Data bit of that sync command (1 = update, 0 = clear) |
| dac_code | output | 10 | Output-stage converter code |
| pwr_down | output | 1 | Output-stage power-down flag |
| ref_internal | output | 1 | Output-stage reference select (1 = internal) |

## Verification
Every byte and event pulse is registered once. A control or code byte reaches the input stage on the edge that samples it. An update, clear or abort shows at the outputs or at the byte position one cycle after its pulse. The bench drives each pulse for exactly one clock from a falling edge and samples the outputs at the next falling edge, after the single register has settled. Effects that are meant to be hidden are exposed by a later STOP or sync command that moves the input stage to the outputs.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  // control byte field positions (decoded by the input stage)
  localparam int SYNC_BIT = 0;
  localparam int PDN_BIT  = 1;
  localparam int REF_BIT  = 2;

  typedef struct packed {
    logic ref_int;
    logic pdn;
    logic sync_mode;
  } ctrl_t;

  typedef enum logic [1:0] {POS_CTRL, POS_LO, POS_HI, POS_DONE} pos_e;
endpackage

// File: rtl/dac_dbuf_frame.sv
module dac_dbuf_frame
  import dac_dbuf_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              wipe,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              ctrl_we,
  output logic              code_we,
  output logic [CODE_W-1:0] code_word,
  output pos_e              pos
);
  localparam int HI_W = CODE_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q;
  logic              take;

  always_comb begin
    take      = rx_valid && !boundary && !wipe;
    ctrl_we   = take && (pos == POS_CTRL);
    code_we   = take && (pos == POS_HI);
    code_word = {rx_data[HI_W-1:0], lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      pos  <= POS_CTRL;
      lo_q <= '0;
    end else if (boundary) begin
      pos <= POS_CTRL;
    end else if (take) begin
      if (pos == POS_LO) lo_q <= rx_data;
      if (pos != POS_DONE) pos <= pos_e'(pos + 2'd1);
    end
  end
endmodule

// File: rtl/dac_dbuf_input.sv
module dac_dbuf_input
  import dac_dbuf_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_byte,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_word,
  output ctrl_t             in_ctrl,
  output logic [CODE_W-1:0] in_code
);
  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      in_ctrl <= '0;
      in_code <= '0;
    end else begin
      if (ctrl_we) begin
        in_ctrl.sync_mode <= ctrl_byte[SYNC_BIT];
        in_ctrl.pdn       <= ctrl_byte[PDN_BIT];
        in_ctrl.ref_int   <= ctrl_byte[REF_BIT];
      end
      if (code_we) in_code <= code_word;
    end
  end
endmodule

// File: rtl/dac_dbuf_output.sv
module dac_dbuf_output
  import dac_dbuf_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              xfer,
  input  ctrl_t             in_ctrl,
  input  logic [CODE_W-1:0] in_code,
  output ctrl_t             out_ctrl,
  output logic [CODE_W-1:0] out_code
);
  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      out_ctrl <= '0;
      out_code <= '0;
    end else if (xfer) begin
      out_ctrl <= in_ctrl;
      out_code <= in_code;
    end
  end
endmodule

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs
  import dac_dbuf_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_stop,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              sync_hit,
  input  logic              sync_arg,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              ref_internal
);
  logic              wipe, boundary, xfer, ctrl_we, code_we, in_sync;
  logic [CODE_W-1:0] code_word, in_code;
  ctrl_t             in_ctrl, out_ctrl;
  pos_e              byte_pos;

  always_comb begin
    rx_ready     = 1'b1;
    wipe         = sync_hit && !sync_arg;
    boundary     = frame_start || frame_stop;
    in_sync      = in_ctrl.sync_mode;
    xfer         = (frame_stop && !in_sync) || (sync_hit && sync_arg && in_sync);
    pwr_down     = out_ctrl.pdn;
    ref_internal = out_ctrl.ref_int;
  end

  dac_dbuf_frame #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .wipe(wipe),
    .rx_valid(rx_valid), .rx_data(rx_data), .ctrl_we(ctrl_we),
    .code_we(code_we), .code_word(code_word), .pos(byte_pos)
  );

  dac_dbuf_input #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_input (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .ctrl_we(ctrl_we),
    .ctrl_byte(rx_data), .code_we(code_we), .code_word(code_word),
    .in_ctrl(in_ctrl), .in_code(in_code)
  );

  dac_dbuf_output #(.CODE_W(CODE_W)) u_output (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .xfer(xfer),
    .in_ctrl(in_ctrl), .in_code(in_code),
    .out_ctrl(out_ctrl), .out_code(dac_code)
  );
endmodule

// File: rtl/dac_dbuf_regs_chk.sv
module dac_dbuf_regs_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              frame_stop,
  input logic              sync_hit,
  input logic              sync_arg,
  input logic              in_sync,
  input logic [1:0]        byte_pos,
  input logic [CODE_W-1:0] dac_code,
  input logic              pwr_down,
  input logic              ref_internal
);
  logic [CODE_W+1:0] outs;
  assign outs = {dac_code, pwr_down, ref_internal};

  // R4: outputs move only after a STOP or a sync command
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stop && !sync_hit) |=> $stable(outs));

  // R5: STOP in synchronous mode does not update
  assert_stop_in_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stop && in_sync && !sync_hit) |=> $stable(outs));

  // R7: clearing sync command zeroes the outputs
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !sync_arg) |=> (outs == '0));

  // R8: updating sync command ignored in STOP mode
  assert_sync_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && sync_arg && !in_sync && !frame_stop) |=> $stable(outs));

  // R10: a bus boundary returns to the control byte position
  assert_boundary_pos_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start || frame_stop) |=> (byte_pos == 2'd0));
endmodule

bind dac_dbuf_regs dac_dbuf_regs_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
  .sync_hit(sync_hit), .sync_arg(sync_arg), .in_sync(in_sync),
  .byte_pos(byte_pos), .dac_code(dac_code), .pwr_down(pwr_down),
  .ref_internal(ref_internal)
);

// File: tb/test_dac_dbuf_regs.sv
module test_dac_dbuf_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, frame_stop = 1'b0;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic       sync_hit = 1'b0, sync_arg = 1'b0;
  logic [9:0] dac_code;
  logic       pwr_down, ref_internal;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  int       m_pos;
  logic [7:0] m_lo;
  logic     m_sy, m_sd, m_bg, o_sd, o_bg;
  logic [9:0] m_code, o_code;

  always #4 clk = ~clk;

  dac_dbuf_regs i_dac_dbuf_regs (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_hit(sync_hit), .sync_arg(sync_arg), .dac_code(dac_code),
    .pwr_down(pwr_down), .ref_internal(ref_internal)
  );

  function automatic logic [9:0] join_code(logic [7:0] hi, logic [7:0] lo);
    return {hi[1:0], lo};
  endfunction

  task automatic m_clear();
    m_pos = 0; m_lo = 0; m_sy = 0; m_sd = 0; m_bg = 0; m_code = 0;
    o_sd = 0; o_bg = 0; o_code = 0;
  endtask

  task automatic m_xfer();
    o_code = m_code; o_sd = m_sd; o_bg = m_bg;
  endtask

  task automatic check(string req);
    n_tests++;
    if (dac_code !== o_code || pwr_down !== o_sd || ref_internal !== o_bg ||
        rx_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: got code=%h pd=%b ref=%b rdy=%b exp code=%h pd=%b ref=%b rdy=1",
               req, dac_code, pwr_down, ref_internal, rx_ready, o_code, o_sd, o_bg);
    end
  endtask

  // one cycle with any combination of events; model applies priority (R13)
  task automatic step(bit st, bit sp, bit bv, logic [7:0] b, bit sh, bit sa, string req);
    @(negedge clk);
    frame_start = st; frame_stop = sp; rx_valid = bv; rx_data = b;
    sync_hit = sh; sync_arg = sa;
    @(negedge clk);
    frame_start = 0; frame_stop = 0; rx_valid = 0; sync_hit = 0; sync_arg = 0;
    if (sh && !sa) m_clear();
    else begin
      if (bv && !st && !sp) begin
        case (m_pos)
          0: begin m_sy = b[0]; m_sd = b[1]; m_bg = b[2]; m_pos = 1; end
          1: begin m_lo = b; m_pos = 2; end
          2: begin m_code = join_code(b, m_lo); m_pos = 3; end
          default: ;
        endcase
      end
      if ((sp && !m_sy) || (sh && sa && m_sy)) m_xfer();
      if (st || sp) m_pos = 0;
    end
    check(req);
  endtask

  task automatic put(logic [7:0] b, string req);  step(0, 0, 1, b, 0, 0, req); endtask
  task automatic stop(string req);                step(0, 1, 0, 8'h00, 0, 0, req); endtask
  task automatic start(string req);               step(1, 0, 0, 8'h00, 0, 0, req); endtask
  task automatic sync(bit a, string req);         step(0, 0, 0, 8'h00, 1, a, req); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset");

    // R2 R3: control 0xFC -> ref only, upper bits ignored; high 0xFE -> code bits 9..8 = 2
    start("R10 start");
    put(8'hFC, "R2 ctrl byte"); put(8'hA5, "R3 low"); put(8'hFE, "R3 high");
    check("R4 no update before stop");
    stop("R4 stop transfer R2 R3");

    // R5 R6: synchronous mode
    start("R10"); put(8'h03, "R2 sync+pdn"); put(8'h3C, "R3"); put(8'h01, "R3");
    stop("R5 stop in sync mode");
    sync(1, "R6 sync update");

    // R8: STOP mode restored via repeated start, new code pending
    start("R10"); put(8'h01, "R2"); put(8'h77, "R3"); put(8'h02, "R3");
    start("R9 repeated start"); put(8'h00, "R2 stop mode");
    start("R10");
    sync(1, "R8 sync ignored in stop mode");
    stop("R4 stop after R8");

    // R9: data dropped on abort after control byte
    start("R10"); put(8'h04, "R2"); put(8'h11, "R3 low then abort");
    stop("R9 abort keeps control drops data");

    // R11: power-down keeps code
    start("R10"); put(8'h06, "R11 pdn on"); stop("R11 pdn on");
    start("R10"); put(8'h00, "R11 pdn off"); stop("R11 code restored");

    // R12: fourth byte ignored
    start("R10"); put(8'h00, "R2"); put(8'h5A, "R3"); put(8'h03, "R3");
    put(8'hFF, "R12 extra byte"); stop("R12 extra byte ignored");

    // R10: frame cut before control byte changes nothing
    start("R10"); stop("R10 empty frame");

    // R13: byte coinciding with stop is dropped; clear beats stop
    start("R10"); step(0, 1, 1, 8'h07, 0, 0, "R13 byte with stop dropped");
    start("R10"); put(8'h04, "R2"); put(8'h99, "R3"); put(8'h01, "R3");
    step(0, 1, 0, 8'h00, 1, 0, "R13 R7 clear beats stop");
    sync(0, "R7 clear again");

    // constrained random frames
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      int kind = $urandom_range(0, 9);
      if (kind < 7) begin
        int nb = $urandom_range(0, 4);
        start("R10 random");
        for (int k = 0; k < nb; k++) put(8'($urandom()), "R2 R3 random byte");
        if ($urandom_range(0, 3) == 0) start("R9 random abort");
        else stop("R4 R5 random stop");
      end else if (kind < 9) sync(1, "R6 R8 random sync");
      else sync($urandom_range(0, 3) != 0, "R7 random sync");
    end

    finish_run();
  end
endmodule